// File: doc/BRIEF.md
# UART Interrupt Priority Selector

This block sits beside the line logic of a 16550-style serial port and decides which interrupt the host sees. It collects five kinds of event: a receive line error, the receive FIFO reaching its trigger level, a receive timeout, the transmit holding register becoming empty, and a change on the modem or flow-control inputs. Each event is gated by its interrupt enable bit. Of the enabled, pending sources, only the one with the highest priority is presented, as a 4-bit identification code together with an active interrupt line.

The line-error, transmit-empty and modem sources are sticky and stay pending until the host services them. The line-error source clears when the line status register is read. The modem source clears when the modem status register is read. The transmit-empty source clears when the holding register is written, or when the interrupt status register is read while transmit-empty is the reported source. The two receive sources are levels that the FIFO logic drives directly. They share one priority level and clear themselves when the FIFO is drained. After reset the transmit-empty source is already pending, so an enabled transmit interrupt is raised straight away.

Register decoding and the FIFOs belong to neighbouring blocks. They provide the enable bits, the event inputs and the read and write strobes.

Top module: `uart_irq_sel`

## Requirements
- R1: In the first cycle after reset, with no events, the transmit-empty source is pending. `irq_id_o` is 0010 and `irq_o` is 1 when enable bit 1 is set. It is 0001 with `irq_o` at 0 when all enables are clear.
- R2: Priority from highest to lowest is line error, then receive data or timeout, then transmit empty, then modem change. Only the highest enabled pending source is reported.
- R3: Codes are 0110 for line error, 0100 for receive data, 1100 for receive timeout, 0010 for transmit empty, 0000 for modem change and 0001 for no interrupt.
- R4: Enable bits are bit 0 for receive data and timeout, bit 1 for transmit empty, bit 2 for line error and bit 3 for modem change. A cleared enable bit hides its source but does not discard a pending sticky source, which appears as soon as the bit is set again.
- R5: A `line_err_i` pulse makes the line-error source pending from the next cycle. It stays pending until an `lsr_rd_i` pulse, after which it is gone from the next cycle.
- R6: Receive data is reported while `rx_trig_i` is high. Timeout is reported while `rx_tmo_i` is high and `rx_trig_i` is low. Neither is stored.
- R7: The transmit-empty source is set by a `thr_empty_i` pulse. It is cleared by a `thr_wr_i` pulse, or by an `isr_rd_i` pulse in a cycle where 0010 is the reported code. An `isr_rd_i` pulse while another code is reported leaves it pending.
- R8: A `ms_chg_i` pulse makes the modem source pending. An `msr_rd_i` pulse clears it from the next cycle.
- R9: `irq_o` is high exactly when the reported code differs from 0001.
- R10: When a set event and its clear strobe arrive in the same cycle, the source is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en_i | input | 4 | Interrupt enable bits (see R4) |
| line_err_i | input | 1 | Receive line error event pulse |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo_i | input | 1 | Receive timeout condition |
| thr_empty_i | input | 1 | Transmit holding register became empty |
| ms_chg_i | input | 1 | Modem or flow-control input change pulse |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| isr_rd_i | input | 1 | Interrupt status register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| irq_id_o | output | 4 | Identification code of the reported source |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A sticky flag that is wrong shows on `irq_id_o` in the first cycle its source becomes the highest enabled one. The bench therefore places every combination of the three sticky flags, the two receive levels and the sixteen enable patterns in front of the output and compares the code after each setup. A clear that misses, or that reaches too far, shows one cycle after the strobe, as a code that stays or a lower source that appears. The isr-read path is checked both while transmit-empty is reported and while it is hidden behind a line error.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int ID_W = 4;
   localparam int EN_W = 4;

   localparam logic [ID_W-1:0] ID_NONE = 4'b0001;
   localparam logic [ID_W-1:0] ID_LINE = 4'b0110;
   localparam logic [ID_W-1:0] ID_RXD  = 4'b0100;
   localparam logic [ID_W-1:0] ID_TMO  = 4'b1100;
   localparam logic [ID_W-1:0] ID_THR  = 4'b0010;
   localparam logic [ID_W-1:0] ID_MS   = 4'b0000;

   localparam int EN_RX   = 0;
   localparam int EN_THR  = 1;
   localparam int EN_LINE = 2;
   localparam int EN_MS   = 3;

   // sticky flag slots
   localparam int NFLAG  = 3;
   localparam int F_LINE = 0;
   localparam int F_THR  = 1;
   localparam int F_MS   = 2;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_d;

   generate
      if (SET_WINS) begin : g_set_wins
         assign q_d = set_i | (q_o & ~clr_i);
      end else begin : g_clr_wins
         assign q_d = ~clr_i & (q_o | set_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= q_d;
   end
endmodule

// File: rtl/uart_irq_pick.sv
module uart_irq_pick
   import uart_irq_pkg::*;
#(
   parameter bit TMO_FIRST = 1'b0
) (
   input  logic            line_v,
   input  logic            rxd_v,
   input  logic            tmo_v,
   input  logic            thr_v,
   input  logic            ms_v,
   output logic [ID_W-1:0] id_o,
   output logic            any_o
);
   logic [ID_W-1:0] rx_id;
   logic            rx_any;

   // order inside the shared receive level
   generate
      if (TMO_FIRST) begin : g_tmo_first
         assign rx_id = tmo_v ? ID_TMO : ID_RXD;
      end else begin : g_rxd_first
         assign rx_id = rxd_v ? ID_RXD : ID_TMO;
      end
   endgenerate
   assign rx_any = rxd_v | tmo_v;

   always_comb begin
      if (line_v)      id_o = ID_LINE;
      else if (rx_any) id_o = rx_id;
      else if (thr_v)  id_o = ID_THR;
      else if (ms_v)   id_o = ID_MS;
      else             id_o = ID_NONE;
   end

   assign any_o = line_v | rx_any | thr_v | ms_v;
endmodule

// File: rtl/uart_irq_sel.sv
module uart_irq_sel
   import uart_irq_pkg::*;
#(
   parameter bit TX_PEND_RST = 1'b1,
   parameter bit SET_WINS    = 1'b1,
   parameter bit TMO_FIRST   = 1'b0,
   parameter int IDW         = ID_W,
   parameter int ENW         = EN_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [ENW-1:0] irq_en_i,
   input  logic           line_err_i,
   input  logic           rx_trig_i,
   input  logic           rx_tmo_i,
   input  logic           thr_empty_i,
   input  logic           ms_chg_i,
   input  logic           lsr_rd_i,
   input  logic           msr_rd_i,
   input  logic           isr_rd_i,
   input  logic           thr_wr_i,
   output logic [IDW-1:0] irq_id_o,
   output logic           irq_o
);
   localparam logic [NFLAG-1:0] RST_VEC = {1'b0, TX_PEND_RST, 1'b0};

   if (IDW != ID_W) begin : g_bad_idw
      $error("uart_irq_sel: IDW must equal the package code width");
   end
   if (ENW != EN_W) begin : g_bad_enw
      $error("uart_irq_sel: ENW must equal the enable field width");
   end

   logic [NFLAG-1:0] set_v, clr_v, pend_v;
   logic [IDW-1:0]   id_w;
   logic             any_w;

   assign set_v[F_LINE] = line_err_i;
   assign clr_v[F_LINE] = lsr_rd_i;
   assign set_v[F_THR]  = thr_empty_i;
   assign clr_v[F_THR]  = thr_wr_i | (isr_rd_i && id_w == ID_THR);
   assign set_v[F_MS]   = ms_chg_i;
   assign clr_v[F_MS]   = msr_rd_i;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      uart_irq_flag #(
         .RST_VAL  (RST_VEC[i]),
         .SET_WINS (SET_WINS)
      ) flag_i (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[i]),
         .clr_i (clr_v[i]),
         .q_o   (pend_v[i])
      );
   end

   uart_irq_pick #(
      .TMO_FIRST (TMO_FIRST)
   ) pick_i (
      .line_v (pend_v[F_LINE] & irq_en_i[EN_LINE]),
      .rxd_v  (rx_trig_i      & irq_en_i[EN_RX]),
      .tmo_v  (rx_tmo_i       & irq_en_i[EN_RX]),
      .thr_v  (pend_v[F_THR]  & irq_en_i[EN_THR]),
      .ms_v   (pend_v[F_MS]   & irq_en_i[EN_MS]),
      .id_o   (id_w),
      .any_o  (any_w)
   );

   assign irq_id_o = id_w;
   assign irq_o    = any_w;
endmodule

// File: rtl/uart_irq_sel_chk.sv
module uart_irq_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] irq_en_i,
   input logic       line_err_i,
   input logic       rx_trig_i,
   input logic       ms_chg_i,
   input logic       thr_empty_i,
   input logic       lsr_rd_i,
   input logic       msr_rd_i,
   input logic       thr_wr_i,
   input logic [3:0] irq_id_o,
   input logic       irq_o
);
   // R5: a line status read with no new error removes the line code
   a_r5_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd_i && !line_err_i) |=> (irq_id_o != 4'b0110));

   // R8: a modem status read with no new change removes the modem code
   a_r8_msr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd_i && !ms_chg_i) |=> (irq_id_o != 4'b0000));

   // R7: a holding register write with no new empty event removes the transmit code
   a_r7_thr_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr_i && !thr_empty_i) |=> (irq_id_o != 4'b0010));

   // R2: a fresh enabled line error outranks everything
   a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(line_err_i) && irq_en_i[2]) |-> (irq_id_o == 4'b0110));

   // R6: enabled receive trigger is reported unless a line error is
   a_r6_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i[0] && rx_trig_i && irq_id_o != 4'b0110) |-> (irq_id_o == 4'b0100));

   // R4: nothing is reported with all enables clear
   a_r4_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i == 4'b0000) |-> (irq_id_o == 4'b0001 && !irq_o));
endmodule

bind uart_irq_sel uart_irq_sel_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_en_i    (irq_en_i),
   .line_err_i  (line_err_i),
   .rx_trig_i   (rx_trig_i),
   .ms_chg_i    (ms_chg_i),
   .thr_empty_i (thr_empty_i),
   .lsr_rd_i    (lsr_rd_i),
   .msr_rd_i    (msr_rd_i),
   .thr_wr_i    (thr_wr_i),
   .irq_id_o    (irq_id_o),
   .irq_o       (irq_o)
);

// File: tb/uart_irq_sel_tb_top.sv
module uart_irq_sel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] en = 4'b0000;
   logic       lerr = 0, rtrig = 0, rtmo = 0, temp = 0, msc = 0;
   logic       lsrrd = 0, msrrd = 0, isrrd = 0, thrwr = 0;
   logic [3:0] id;
   logic       irq;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   uart_irq_sel dut_i (
      .clk (clk), .rst_n (rst_n), .irq_en_i (en),
      .line_err_i (lerr), .rx_trig_i (rtrig), .rx_tmo_i (rtmo),
      .thr_empty_i (temp), .ms_chg_i (msc),
      .lsr_rd_i (lsrrd), .msr_rd_i (msrrd), .isr_rd_i (isrrd), .thr_wr_i (thrwr),
      .irq_id_o (id), .irq_o (irq)
   );

   function automatic logic [3:0] model(input logic [3:0] e, input logic ln, input logic tr,
                                         input logic tm, input logic tx, input logic ms);
      if (ln && e[2])      return 4'b0110;
      else if (tr && e[0]) return 4'b0100;
      else if (tm && e[0]) return 4'b1100;
      else if (tx && e[1]) return 4'b0010;
      else if (ms && e[3]) return 4'b0000;
      return 4'b0001;
   endfunction

   task automatic check(input string req, input logic [3:0] exp_id);
      logic exp_irq;
      exp_irq = (exp_id != 4'b0001);
      n_chk++;
      if (id !== exp_id || irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", req, id, irq, exp_id, exp_irq);
      end
   endtask

   task automatic step();
      @(negedge clk);
      lerr = 0; temp = 0; msc = 0; lsrrd = 0; msrrd = 0; isrrd = 0; thrwr = 0;
   endtask

   // clears all sticky flags, then sets the chosen ones
   task automatic load(input logic ln, input logic tx, input logic ms);
      @(negedge clk);
      lsrrd = 1; msrrd = 1; thrwr = 1;
      step();
      lerr = ln; temp = tx; msc = ms;
      step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      en = 4'b0010;
      rst_n = 1'b1;
      #1 check("R1 transmit pending after reset", 4'b0010);
      en = 4'b0000;
      #1 check("R1 masked after reset", 4'b0001);

      // R2 R3 R6 R9 sweep over every enable, level and flag pattern
      for (int e = 0; e < 16; e++)
         for (int f = 0; f < 8; f++)
            for (int r = 0; r < 4; r++) begin
               load(f[0], f[1], f[2]);
               en = e[3:0]; rtrig = r[0]; rtmo = r[1];
               #1 check("R2/R3/R6/R9 sweep", model(e[3:0], f[0], r[0], r[1], f[1], f[2]));
            end
      rtrig = 0; rtmo = 0;

      // R7 isr read clears transmit while it is reported
      en = 4'b1111;
      load(0, 1, 0);
      #1 check("R7 transmit reported", 4'b0010);
      @(negedge clk); isrrd = 1;
      step();
      #1 check("R7 isr read clears transmit", 4'b0001);

      // R7 isr read while line error reported keeps transmit
      load(1, 1, 0);
      @(negedge clk); isrrd = 1;
      step();
      #1 check("R7 isr read behind line error", 4'b0110);
      @(negedge clk); lsrrd = 1;
      step();
      #1 check("R5 line read reveals transmit", 4'b0010);

      // R10 set and clear together
      load(0, 0, 0);
      @(negedge clk); lerr = 1; lsrrd = 1;
      step();
      #1 check("R10 line set wins", 4'b0110);
      load(0, 0, 0);
      @(negedge clk); temp = 1; thrwr = 1;
      step();
      #1 check("R10 transmit set wins", 4'b0010);

      // R4 R8 retention while masked, then modem read
      load(0, 0, 1);
      en = 4'b0000;
      repeat (3) @(negedge clk);
      #1 check("R4 masked modem hidden", 4'b0001);
      en = 4'b1000;
      #1 check("R4 modem kept while masked", 4'b0000);
      @(negedge clk); msrrd = 1;
      step();
      #1 check("R8 modem read clears", 4'b0001);

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule